// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between a UART's line deserializer, its host data register and its two byte FIFOs. A two-bit channel-mode input decides where each byte goes. A byte from the line can go to the receive FIFO, to the transmit FIFO, or to both. A byte the host writes to the data register can go to the transmit FIFO, to the receive FIFO, or be discarded. A host read of the data register pops the receive FIFO. The FIFO storage stays outside the block. The FIFOs report their fill counts, and the block drives push, pop and flush strobes back to them.

The block holds the channel control register. That register carries one enable bit and one disable bit per direction, which open or close FIFO access. It also carries two self-clearing flush bits, and the stored break-control bits pass through to the register's output. The router reports overruns when a byte meets a full FIFO. It also computes how many bytes the line side may still deliver before a FIFO it feeds is full.

Top module: `chan_route`

## Requirements
- R1: After reset, ctrl_o reads 0x128: bit 3 (RX disable), bit 5 (TX disable) and bit 8 (stop-break) are set. No push, pop, flush or overrun strobe is active.
- R2: mode_i uses these codes: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. A line byte (line_valid_i) is pushed to the RX FIFO in modes 0 and 1, and to the TX FIFO in modes 1 and 3. In mode 2 it is dropped.
- R3: A host data write (host_wr_i) is pushed to the TX FIFO in mode 0 and to the RX FIFO in mode 2. In modes 1 and 3 it is dropped.
- R4: RX FIFO pushes and pops happen only while ctrl_o bit 2 (RX enable) is 1 and bit 3 (RX disable) is 0. TX pushes happen only while bit 4 (TX enable) is 1 and bit 5 (TX disable) is 0. A byte blocked this way is dropped without an overrun.
- R5: When a byte aimed at an open RX FIFO finds rxf_count_i equal to RX_DEPTH, it is not pushed, and rx_ovr_o is high for exactly the following cycle.
- R6: When a byte aimed at an open TX FIFO finds txf_count_i equal to TX_DEPTH, it is not pushed, and tx_ovr_o is high for exactly the following cycle.
- R7: A host read with the RX FIFO open and not empty raises rxf_pop_o and returns the FIFO head on host_rdata_o in the same cycle. Otherwise host_rdata_o is 0 and no pop occurs.
- R8: A control write stores ctrl_wdata_i into ctrl_o with bits 1:0 cleared. A 1 in bit 0 (or bit 1) of the written value pulses rxf_flush_o (or txf_flush_o) in the cycle after the write.
- R9: space_o is the smallest free count among the FIFOs that the current mode feeds from the line: RX in modes 0 and 1, TX in modes 1 and 3. In mode 2 it is the larger of the two depths.
- R10: A line break (line_break_i) is pushed to the RX FIFO as a zero byte in modes 0 and 1. It takes precedence over line_valid_i and is never sent to the TX FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 9 | Control register write value |
| ctrl_o | output | 9 | Control register contents |
| line_valid_i | input | 1 | Byte received from the line |
| line_break_i | input | 1 | Break received from the line |
| line_data_i | input | DW | Received line byte |
| host_wr_i | input | 1 | Host write to the data register |
| host_wdata_i | input | DW | Host write byte |
| host_rd_i | input | 1 | Host read of the data register |
| host_rdata_o | output | DW | Host read byte (0 when nothing is popped) |
| rxf_push_o | output | 1 | RX FIFO push |
| rxf_wdata_o | output | DW | RX FIFO push byte |
| rxf_pop_o | output | 1 | RX FIFO pop |
| rxf_rdata_i | input | DW | RX FIFO head byte |
| rxf_count_i | input | $clog2(RX_DEPTH+1) | RX FIFO fill count |
| rxf_flush_o | output | 1 | RX FIFO flush |
| txf_push_o | output | 1 | TX FIFO push |
| txf_wdata_o | output | DW | TX FIFO push byte |
| txf_count_i | input | $clog2(TX_DEPTH+1) | TX FIFO fill count |
| txf_flush_o | output | 1 | TX FIFO flush |
| rx_ovr_o | output | 1 | RX overrun pulse |
| tx_ovr_o | output | 1 | TX overrun pulse |
| space_o | output | $clog2(max(RX_DEPTH,TX_DEPTH)+1) | Bytes the line side may still deliver |

## Verification
The bench builds the router with RX_DEPTH 4 and TX_DEPTH 6. With those depths both FIFOs fill after a handful of bytes, so overrun in each direction is reached quickly, and so are the flush that recovers from it and a space_o of zero. Because the two depths differ, the minimum in echo mode and the fallback to the larger depth in local loopback each produce a value that can be told apart from the other cases. A behavioural FIFO in the bench closes the count and head-data loop, so routing, gating and read-back are checked over the sequence of bytes each FIFO receives.

// File: rtl/chan_route_pkg.sv
package chan_route_pkg;

  typedef enum logic [1:0] {
    CM_NORMAL = 2'd0,
    CM_ECHO   = 2'd1,
    CM_LOCAL  = 2'd2,
    CM_REMOTE = 2'd3
  } chan_mode_e;

  localparam int CTRL_W = 9;

  // control bit positions
  localparam int CB_RX_FLUSH = 0;
  localparam int CB_TX_FLUSH = 1;
  localparam int CB_RX_EN    = 2;
  localparam int CB_RX_DIS   = 3;
  localparam int CB_TX_EN    = 4;
  localparam int CB_TX_DIS   = 5;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;

  function automatic logic mode_line_rx(chan_mode_e m);
    return (m == CM_NORMAL) || (m == CM_ECHO);
  endfunction

  function automatic logic mode_line_tx(chan_mode_e m);
    return (m == CM_ECHO) || (m == CM_REMOTE);
  endfunction

endpackage

// File: rtl/chan_ctrl_reg.sv
module chan_ctrl_reg
  import chan_route_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              rx_open_o,
  output logic              tx_open_o,
  output logic              rx_flush_o,
  output logic              tx_flush_o
);

  localparam logic [CTRL_W-1:0] SELF_CLR = CTRL_W'((1 << CB_RX_FLUSH) | (1 << CB_TX_FLUSH));

  logic [CTRL_W-1:0] ctrl_q;
  logic [1:0]        flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RESET;
      flush_q <= 2'b00;
    end else begin
      flush_q <= wr_i ? {wdata_i[CB_TX_FLUSH], wdata_i[CB_RX_FLUSH]} : 2'b00;
      if (wr_i) ctrl_q <= wdata_i & ~SELF_CLR;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign rx_open_o  = ctrl_q[CB_RX_EN] & ~ctrl_q[CB_RX_DIS];
  assign tx_open_o  = ctrl_q[CB_TX_EN] & ~ctrl_q[CB_TX_DIS];
  assign rx_flush_o = flush_q[0];
  assign tx_flush_o = flush_q[1];

endmodule

// File: rtl/chan_steer.sv
module chan_steer
  import chan_route_pkg::*;
#(
  parameter int DW = 8
) (
  input  chan_mode_e    mode_i,
  input  logic          line_valid_i,
  input  logic          line_break_i,
  input  logic [DW-1:0] line_data_i,
  input  logic          host_wr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_rd_i,
  input  logic          rx_open_i,
  input  logic          tx_open_i,
  input  logic          rx_full_i,
  input  logic          tx_full_i,
  input  logic          rx_empty_i,
  input  logic [DW-1:0] rx_head_i,
  output logic          rx_push_o,
  output logic [DW-1:0] rx_wdata_o,
  output logic          tx_push_o,
  output logic [DW-1:0] tx_wdata_o,
  output logic          rx_pop_o,
  output logic [DW-1:0] host_rdata_o,
  output logic          rx_ovr_hit_o,
  output logic          tx_ovr_hit_o
);

  logic          line_rx_req, line_tx_req, host_rx_req, host_tx_req;
  logic          rx_req, tx_req;
  logic [DW-1:0] line_byte;

  // a break replaces the byte with zero and is never looped to TX
  assign line_byte   = line_break_i ? '0 : line_data_i;
  assign line_rx_req = mode_line_rx(mode_i) & (line_valid_i | line_break_i);
  assign line_tx_req = mode_line_tx(mode_i) & line_valid_i & ~line_break_i;
  assign host_tx_req = (mode_i == CM_NORMAL) & host_wr_i;
  assign host_rx_req = (mode_i == CM_LOCAL)  & host_wr_i;

  // modes never give one FIFO two sources at once
  assign rx_req     = line_rx_req | host_rx_req;
  assign tx_req     = line_tx_req | host_tx_req;
  assign rx_wdata_o = host_rx_req ? host_wdata_i : line_byte;
  assign tx_wdata_o = host_tx_req ? host_wdata_i : line_data_i;

  assign rx_push_o    = rx_req & rx_open_i & ~rx_full_i;
  assign tx_push_o    = tx_req & tx_open_i & ~tx_full_i;
  assign rx_ovr_hit_o = rx_req & rx_open_i & rx_full_i;
  assign tx_ovr_hit_o = tx_req & tx_open_i & tx_full_i;

  assign rx_pop_o     = host_rd_i & rx_open_i & ~rx_empty_i;
  assign host_rdata_o = rx_pop_o ? rx_head_i : '0;

endmodule

// File: rtl/chan_space.sv
module chan_space
  import chan_route_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  localparam int MAXD = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
  localparam int RXCW = $clog2(RX_DEPTH + 1),
  localparam int TXCW = $clog2(TX_DEPTH + 1),
  localparam int SW   = $clog2(MAXD + 1)
) (
  input  chan_mode_e      mode_i,
  input  logic [RXCW-1:0] rx_count_i,
  input  logic [TXCW-1:0] tx_count_i,
  output logic [SW-1:0]   space_o
);

  logic [SW-1:0] rx_free, tx_free;

  assign rx_free = SW'(RX_DEPTH) - SW'(rx_count_i);
  assign tx_free = SW'(TX_DEPTH) - SW'(tx_count_i);

  always_comb begin
    space_o = SW'(MAXD);
    if (mode_line_rx(mode_i) && rx_free < space_o) space_o = rx_free;
    if (mode_line_tx(mode_i) && tx_free < space_o) space_o = tx_free;
  end

endmodule

// File: rtl/chan_route.sv
module chan_route
  import chan_route_pkg::*;
#(
  parameter int DW       = 8,
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  localparam int MAXD = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
  localparam int RXCW = $clog2(RX_DEPTH + 1),
  localparam int TXCW = $clog2(TX_DEPTH + 1),
  localparam int SW   = $clog2(MAXD + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic              line_valid_i,
  input  logic              line_break_i,
  input  logic [DW-1:0]     line_data_i,
  input  logic              host_wr_i,
  input  logic [DW-1:0]     host_wdata_i,
  input  logic              host_rd_i,
  output logic [DW-1:0]     host_rdata_o,
  output logic              rxf_push_o,
  output logic [DW-1:0]     rxf_wdata_o,
  output logic              rxf_pop_o,
  input  logic [DW-1:0]     rxf_rdata_i,
  input  logic [RXCW-1:0]   rxf_count_i,
  output logic              rxf_flush_o,
  output logic              txf_push_o,
  output logic [DW-1:0]     txf_wdata_o,
  input  logic [TXCW-1:0]   txf_count_i,
  output logic              txf_flush_o,
  output logic              rx_ovr_o,
  output logic              tx_ovr_o,
  output logic [SW-1:0]     space_o
);

  chan_mode_e mode;
  logic       rx_open, tx_open;
  logic       rx_full, tx_full, rx_empty;
  logic       rx_ovr_hit, tx_ovr_hit;
  logic       rx_ovr_q, tx_ovr_q;

  assign mode     = chan_mode_e'(mode_i);
  assign rx_full  = rxf_count_i >= RXCW'(RX_DEPTH);
  assign tx_full  = txf_count_i >= TXCW'(TX_DEPTH);
  assign rx_empty = rxf_count_i == '0;

  chan_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctrl_wr_i),
    .wdata_i    (ctrl_wdata_i),
    .ctrl_o     (ctrl_o),
    .rx_open_o  (rx_open),
    .tx_open_o  (tx_open),
    .rx_flush_o (rxf_flush_o),
    .tx_flush_o (txf_flush_o)
  );

  chan_steer #(.DW(DW)) u_steer (
    .mode_i       (mode),
    .line_valid_i (line_valid_i),
    .line_break_i (line_break_i),
    .line_data_i  (line_data_i),
    .host_wr_i    (host_wr_i),
    .host_wdata_i (host_wdata_i),
    .host_rd_i    (host_rd_i),
    .rx_open_i    (rx_open),
    .tx_open_i    (tx_open),
    .rx_full_i    (rx_full),
    .tx_full_i    (tx_full),
    .rx_empty_i   (rx_empty),
    .rx_head_i    (rxf_rdata_i),
    .rx_push_o    (rxf_push_o),
    .rx_wdata_o   (rxf_wdata_o),
    .tx_push_o    (txf_push_o),
    .tx_wdata_o   (txf_wdata_o),
    .rx_pop_o     (rxf_pop_o),
    .host_rdata_o (host_rdata_o),
    .rx_ovr_hit_o (rx_ovr_hit),
    .tx_ovr_hit_o (tx_ovr_hit)
  );

  chan_space #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_space (
    .mode_i     (mode),
    .rx_count_i (rxf_count_i),
    .tx_count_i (txf_count_i),
    .space_o    (space_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_ovr_q <= 1'b0;
      tx_ovr_q <= 1'b0;
    end else begin
      rx_ovr_q <= rx_ovr_hit;
      tx_ovr_q <= tx_ovr_hit;
    end
  end

  assign rx_ovr_o = rx_ovr_q;
  assign tx_ovr_o = tx_ovr_q;

endmodule

// File: rtl/chan_route_chk.sv
module chan_route_chk
  import chan_route_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  localparam int RXCW = $clog2(RX_DEPTH + 1),
  localparam int TXCW = $clog2(TX_DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              ctrl_wr_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              line_valid_i,
  input logic              host_rd_i,
  input logic              host_rdata_nz,
  input logic              rxf_push_o,
  input logic              rxf_pop_o,
  input logic [RXCW-1:0]   rxf_count_i,
  input logic              rxf_flush_o,
  input logic              txf_push_o,
  input logic [TXCW-1:0]   txf_count_i,
  input logic              rx_ovr_o
);

  // R5
  rx_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxf_push_o |-> (rxf_count_i < RXCW'(RX_DEPTH)));

  // R6
  tx_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txf_push_o |-> (txf_count_i < TXCW'(TX_DEPTH)));

  // R4
  rx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_o[CB_RX_EN] && !ctrl_o[CB_RX_DIS]) |-> (!rxf_push_o && !rxf_pop_o));

  // R4
  tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_o[CB_TX_EN] && !ctrl_o[CB_TX_DIS]) |-> !txf_push_o);

  // R8
  rx_flush_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && ctrl_wdata_i[CB_RX_FLUSH]) |=> rxf_flush_o);

  // R7
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && rxf_count_i == '0) |-> (!host_rdata_nz && !rxf_pop_o));

  // R3
  local_no_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2) |-> !txf_push_o);

  // R5
  rx_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_i && mode_i == 2'd0 && ctrl_o[CB_RX_EN] && !ctrl_o[CB_RX_DIS]
     && rxf_count_i == RXCW'(RX_DEPTH)) |=> rx_ovr_o);

endmodule

bind chan_route chan_route_chk #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_i        (mode_i),
  .ctrl_wr_i     (ctrl_wr_i),
  .ctrl_wdata_i  (ctrl_wdata_i),
  .ctrl_o        (ctrl_o),
  .line_valid_i  (line_valid_i),
  .host_rd_i     (host_rd_i),
  .host_rdata_nz (|host_rdata_o),
  .rxf_push_o    (rxf_push_o),
  .rxf_pop_o     (rxf_pop_o),
  .rxf_count_i   (rxf_count_i),
  .rxf_flush_o   (rxf_flush_o),
  .txf_push_o    (txf_push_o),
  .txf_count_i   (txf_count_i),
  .rx_ovr_o      (rx_ovr_o)
);

// File: tb/chan_route_test.sv
module chan_route_test;

  localparam int DW   = 8;
  localparam int RXD  = 4;
  localparam int TXD  = 6;
  localparam int RXCW = $clog2(RXD + 1);
  localparam int TXCW = $clog2(TXD + 1);
  localparam int SW   = $clog2(TXD + 1);

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [1:0]      mode_i = 2'd0;
  logic            ctrl_wr_i = 1'b0;
  logic [8:0]      ctrl_wdata_i = '0;
  logic [8:0]      ctrl_o;
  logic            line_valid_i = 1'b0;
  logic            line_break_i = 1'b0;
  logic [DW-1:0]   line_data_i = '0;
  logic            host_wr_i = 1'b0;
  logic [DW-1:0]   host_wdata_i = '0;
  logic            host_rd_i = 1'b0;
  logic [DW-1:0]   host_rdata_o;
  logic            rxf_push_o, rxf_pop_o, rxf_flush_o;
  logic [DW-1:0]   rxf_wdata_o;
  logic [DW-1:0]   rxf_rdata_i = '0;
  logic [RXCW-1:0] rxf_count_i = '0;
  logic            txf_push_o, txf_flush_o;
  logic [DW-1:0]   txf_wdata_o;
  logic [TXCW-1:0] txf_count_i = '0;
  logic            rx_ovr_o, tx_ovr_o;
  logic [SW-1:0]   space_o;

  int vectors = 0;
  int fails   = 0;

  logic [DW-1:0] rxq[$];
  logic [DW-1:0] txq[$];
  logic [DW-1:0] exp_rx[$];
  logic [DW-1:0] exp_tx[$];

  always #2 clk = ~clk;

  chan_route #(.DW(DW), .RX_DEPTH(RXD), .TX_DEPTH(TXD)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i),
    .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i), .ctrl_o(ctrl_o),
    .line_valid_i(line_valid_i), .line_break_i(line_break_i), .line_data_i(line_data_i),
    .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
    .host_rd_i(host_rd_i), .host_rdata_o(host_rdata_o),
    .rxf_push_o(rxf_push_o), .rxf_wdata_o(rxf_wdata_o), .rxf_pop_o(rxf_pop_o),
    .rxf_rdata_i(rxf_rdata_i), .rxf_count_i(rxf_count_i), .rxf_flush_o(rxf_flush_o),
    .txf_push_o(txf_push_o), .txf_wdata_o(txf_wdata_o), .txf_count_i(txf_count_i),
    .txf_flush_o(txf_flush_o), .rx_ovr_o(rx_ovr_o), .tx_ovr_o(tx_ovr_o),
    .space_o(space_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // FIFO model and scoreboard monitor
  always @(posedge clk) begin
    if (rst_ni) begin
      if (rxf_pop_o && rxq.size() > 0) void'(rxq.pop_front());
      if (rxf_push_o) begin
        if (exp_rx.size() == 0) chk("R2/R3 unexpected RX push", 16'(rxf_wdata_o), 16'hffff);
        else chk("R2 RX push byte", 16'(rxf_wdata_o), 16'(exp_rx.pop_front()));
        rxq.push_back(rxf_wdata_o);
      end
      if (txf_push_o) begin
        if (exp_tx.size() == 0) chk("R3 unexpected TX push", 16'(txf_wdata_o), 16'hffff);
        else chk("R3 TX push byte", 16'(txf_wdata_o), 16'(exp_tx.pop_front()));
        txq.push_back(txf_wdata_o);
      end
      if (rxf_flush_o) rxq.delete();
      if (txf_flush_o) txq.delete();
    end
    rxf_count_i <= RXCW'(rxq.size());
    txf_count_i <= TXCW'(txq.size());
    rxf_rdata_i <= (rxq.size() > 0) ? rxq[0] : '0;
  end

  task automatic line_in(input logic [DW-1:0] d, input bit brk);
    @(negedge clk);
    line_valid_i = !brk; line_break_i = brk; line_data_i = d;
    @(negedge clk);
    line_valid_i = 1'b0; line_break_i = 1'b0;
    #1;
  endtask

  task automatic host_wr(input logic [DW-1:0] d);
    @(negedge clk);
    host_wr_i = 1'b1; host_wdata_i = d;
    @(negedge clk);
    host_wr_i = 1'b0;
    #1;
  endtask

  task automatic host_rd(output logic [DW-1:0] d);
    @(negedge clk);
    host_rd_i = 1'b1;
    #1 d = host_rdata_o;
    @(negedge clk);
    host_rd_i = 1'b0;
    #1;
  endtask

  task automatic ctrl_wr(input logic [8:0] v);
    @(negedge clk);
    ctrl_wr_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk);
    ctrl_wr_i = 1'b0;
    #1;
  endtask

  task automatic settle;
    @(negedge clk);
    #1;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_i = m;
    #1;
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 ctrl reset", 16'(ctrl_o), 16'h128);
    chk("R1 strobes idle", {11'd0, rxf_push_o, txf_push_o, rxf_pop_o, rxf_flush_o, txf_flush_o}, 16'h0);
    chk("R1 overrun idle", {14'd0, rx_ovr_o, tx_ovr_o}, 16'h0);
    @(negedge clk); rst_ni = 1'b1; #1;
    chk("R9 space after reset", 16'(space_o), 16'd4);

    // R4 disabled after reset: bytes dropped without overrun
    line_in(8'h11, 1'b0);
    chk("R4 RX closed drops line byte", 16'(rx_ovr_o), 16'h0);
    host_wr(8'h22);
    settle();
    chk("R4 RX count stays empty", 16'(rxf_count_i), 16'd0);
    chk("R4 TX count stays empty", 16'(txf_count_i), 16'd0);

    // R8 control write stored
    ctrl_wr(9'h014);
    chk("R8 ctrl readback", 16'(ctrl_o), 16'h014);

    // R2 R3 normal mode
    exp_rx.push_back(8'hA1);
    line_in(8'hA1, 1'b0);
    exp_tx.push_back(8'h5A);
    host_wr(8'h5A);
    settle();
    chk("R2 normal RX count", 16'(rxf_count_i), 16'd1);
    chk("R3 normal TX count", 16'(txf_count_i), 16'd1);
    chk("R9 normal space", 16'(space_o), 16'd3);

    // R4 RX disable bit wins over enable
    ctrl_wr(9'h01C);
    line_in(8'h33, 1'b0);
    host_rd(rd);
    chk("R7 read while RX closed", 16'(rd), 16'h0);
    settle();
    chk("R4 RX closed keeps count", 16'(rxf_count_i), 16'd1);
    ctrl_wr(9'h014);

    // R7 reads
    host_rd(rd);
    chk("R7 read head", 16'(rd), 16'hA1);
    chk("R7 RX count after pop", 16'(rxf_count_i), 16'd0);
    host_rd(rd);
    chk("R7 read empty returns zero", 16'(rd), 16'h0);

    // R5 fill RX then overrun
    for (int i = 0; i < RXD; i++) begin
      exp_rx.push_back(8'hB0 + 8'(i));
      line_in(8'hB0 + 8'(i), 1'b0);
    end
    settle();
    chk("R5 RX full count", 16'(rxf_count_i), 16'd4);
    chk("R9 space zero when RX full", 16'(space_o), 16'd0);
    line_in(8'hEE, 1'b0);
    chk("R5 RX overrun pulse", 16'(rx_ovr_o), 16'h1);
    settle();
    chk("R5 RX overrun one cycle", 16'(rx_ovr_o), 16'h0);
    chk("R5 RX count unchanged", 16'(rxf_count_i), 16'd4);

    // R8 RX flush
    ctrl_wr(9'h015);
    chk("R8 RX flush pulse", 16'(rxf_flush_o), 16'h1);
    chk("R8 flush bit self-clears", 16'(ctrl_o), 16'h014);
    settle();
    chk("R8 RX flushed", 16'(rxf_count_i), 16'd0);

    // R2 echo: line byte to both, host dropped
    set_mode(2'd1);
    exp_rx.push_back(8'hC1);
    exp_tx.push_back(8'hC1);
    line_in(8'hC1, 1'b0);
    host_wr(8'h77);
    settle();
    chk("R2 echo RX count", 16'(rxf_count_i), 16'd1);
    chk("R3 echo host dropped", 16'(txf_count_i), 16'd2);
    chk("R9 echo space min", 16'(space_o), 16'd3);

    // R10 break becomes zero byte in RX only
    exp_rx.push_back(8'h00);
    line_in(8'hFF, 1'b1);
    settle();
    chk("R10 break into RX", 16'(rxf_count_i), 16'd2);
    chk("R10 break not echoed", 16'(txf_count_i), 16'd2);

    // R3 local loopback
    set_mode(2'd2);
    chk("R9 local space max depth", 16'(space_o), 16'd6);
    exp_rx.push_back(8'hD1);
    host_wr(8'hD1);
    line_in(8'hD2, 1'b0);
    settle();
    chk("R3 local host to RX", 16'(rxf_count_i), 16'd3);
    chk("R2 local line dropped", 16'(txf_count_i), 16'd2);

    // R2 remote loopback
    set_mode(2'd3);
    chk("R9 remote space TX only", 16'(space_o), 16'd4);
    exp_tx.push_back(8'hE1);
    line_in(8'hE1, 1'b0);
    host_wr(8'h99);
    settle();
    chk("R2 remote line to TX", 16'(txf_count_i), 16'd3);
    chk("R2 remote RX untouched", 16'(rxf_count_i), 16'd3);

    // R6 TX overrun from host in normal mode
    set_mode(2'd0);
    for (int i = 0; i < 3; i++) begin
      exp_tx.push_back(8'hF1 + 8'(i));
      host_wr(8'hF1 + 8'(i));
    end
    settle();
    chk("R6 TX full count", 16'(txf_count_i), 16'd6);
    chk("R9 normal space TX full", 16'(space_o), 16'd1);
    host_wr(8'hF9);
    chk("R6 TX overrun pulse", 16'(tx_ovr_o), 16'h1);
    settle();
    chk("R6 TX count unchanged", 16'(txf_count_i), 16'd6);

    // R8 TX flush
    ctrl_wr(9'h016);
    chk("R8 TX flush pulse", 16'(txf_flush_o), 16'h1);
    settle();
    chk("R8 TX flushed", 16'(txf_count_i), 16'd0);

    // R5 RX overrun via host in local loopback
    set_mode(2'd2);
    exp_rx.push_back(8'hD5);
    host_wr(8'hD5);
    host_wr(8'hD6);
    chk("R5 local RX overrun pulse", 16'(rx_ovr_o), 16'h1);
    settle();
    chk("R5 local RX count", 16'(rxf_count_i), 16'd4);

    chk("R2 expected RX pushes all seen", 16'(exp_rx.size()), 16'd0);
    chk("R3 expected TX pushes all seen", 16'(exp_tx.size()), 16'd0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule